// File: doc/BRIEF.md
# Conversion Result FIFO with Threshold Interrupt

This block holds the conversion results of one conversion group. A converter-side port pushes result words into a circular buffer of programmable depth. A CPU-side port pops them back out in arrival order. Alongside the buffer, a signed threshold counter starts at a programmed value. It steps down for every stored result and up for every result read. When it steps from one to zero it raises a sticky threshold flag, and the flag drives an interrupt line when the interrupt is enabled. The counter holds when a store and a read fall in the same cycle. It returns to the programmed value only when the buffer runs empty.

A full buffer meets a new result in one of two ways, chosen by a register bit. In overwrite mode the oldest word is discarded and the new one is stored. In stall mode a sticky overrun flag is raised, and the buffer refuses all results until the CPU has drained it to empty. A small register port gives access to the threshold, the control bits, the depth, the flags, the live counter and the fill level.

Buffer occupancy is tracked by a four-state machine. EMPTY goes to FILL on a store, or to FULL when the depth is one. FILL goes to FULL when the level reaches the depth, and back to EMPTY when the last word is read. FULL goes to FILL or EMPTY on a read. It goes to STALL on a refused write in stall mode, and stays in FULL on an overwrite or on a store paired with a read. STALL returns to EMPTY once the level reaches zero. Writing the threshold or depth register sends any state back to EMPTY.

Top module: `result_fifo_thresh`

## Requirements
- R1: Stored words leave in the order they arrived. A read issued with `cpu_rd` in cycle t presents the oldest word on `cpu_data`, with `cpu_void` low, from the clock edge that ends cycle t.
- R2: Each stored result, including one that overwrites, lowers the threshold counter by one when no read pops a word in the same cycle.
- R3: Each read that pops a stored word raises the counter by one when no result is stored in the same cycle.
- R4: A store and a pop in the same cycle leave the counter unchanged.
- R5: A step of the counter from 1 to 0 sets the threshold flag (STATUS bit 0). `thr_irq` is high exactly while this flag and the interrupt enable (CTRL, address 1, bit 0) are both set.
- R6: Writing STATUS (address 3) with bit 0 set clears the threshold flag, and with bit 1 set clears the overrun flag. Neither clear changes the counter. A flag set in the same cycle wins over its clear.
- R7: A read that leaves the buffer empty reloads the counter with the programmed threshold.
- R8: With overwrite mode on (CTRL bit 1 = 1), a result arriving at a full buffer replaces the oldest word, and the level stays at the depth.
- R9: With CTRL bit 1 = 0, a result arriving at a full buffer, with no read that cycle, sets the overrun flag (STATUS bit 1) and the stall bit (STATUS bit 4). Every result is then dropped until reads have emptied the buffer.
- R10: A read of an empty buffer sets `cpu_void`, keeps the previous `cpu_data` and leaves the counter unchanged.
- R11: Writing THRESH (address 0) or DEPTH (address 2) empties the buffer, leaves stall, and loads the counter with the threshold now in force. Both flags keep their values.
- R12: The counter is signed. It can go below zero and reads at address 4 sign-extended to 16 bits.
- R13: The depth is the DEPTH field plus one, clamped to the maximum depth. Address 5 reads the fill level. STATUS bit 2 shows empty and bit 3 shows full.
- R14: After reset the buffer is empty, both flags are clear, the enable and overwrite bits are 0, the depth is at its maximum, the counter equals the reset threshold, `cpu_void` is 1 and `cpu_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_valid | input | 1 | Converter presents a result this cycle |
| conv_data | input | DATA_W | Result word from the converter |
| cpu_rd | input | 1 | CPU pops one result |
| cpu_data | output | DATA_W | Word returned by the last read |
| cpu_void | output | 1 | Last read found the buffer empty |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data (combinational) |
| thr_irq | output | 1 | Threshold interrupt request |

## Verification
A store from the converter and a pop by the CPU can land in the same cycle, and the counter must then hold instead of stepping. That case also covers a full buffer, where the pop frees the slot the store takes. The bench provokes it by sweeping every depth from one to eight with interleaved valid and read patterns whose phases drift against each other, in both overflow modes. After every cycle it compares the counter, the level, the flags and the read data with an arithmetic model of the rules.

// File: rtl/rfq_pkg.sv
`timescale 1ns/1ps
package rfq_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_FILL  = 2'd1,
        ST_FULL  = 2'd2,
        ST_STALL = 2'd3
    } rfq_state_e;

    localparam logic [2:0] RA_THRESH = 3'd0;
    localparam logic [2:0] RA_CTRL   = 3'd1;
    localparam logic [2:0] RA_DEPTH  = 3'd2;
    localparam logic [2:0] RA_STATUS = 3'd3;
    localparam logic [2:0] RA_COUNT  = 3'd4;
    localparam logic [2:0] RA_LEVEL  = 3'd5;

    localparam int CB_IEN = 0;
    localparam int CB_IGN = 1;

    localparam int SB_THR   = 0;
    localparam int SB_OVR   = 1;
    localparam int SB_EMPTY = 2;
    localparam int SB_FULL  = 3;
    localparam int SB_STALL = 4;

endpackage

// File: rtl/rfq_ctrl.sv
`timescale 1ns/1ps
module rfq_ctrl
    import rfq_pkg::*;
#(
    parameter int DEPTH_MAX = 64,
    localparam int AW = (DEPTH_MAX > 1) ? $clog2(DEPTH_MAX) : 1,
    localparam int LW = $clog2(DEPTH_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_req,
    input  logic          rd_req,
    input  logic          ovr_ign,
    input  logic [AW-1:0] depth_m1,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic          push,
    output logic          pop,
    output logic          drained,
    output logic          ovr_set,
    output logic [LW-1:0] level,
    output rfq_state_e    state
);

    rfq_state_e    state_q, state_d, settle;
    logic [AW-1:0] wr_ptr_q, rd_ptr_q;
    logic [LW-1:0] level_q, level_d, depth;
    logic          overwrite;

    assign depth = LW'(depth_m1) + LW'(1);

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p,
                                               input logic [AW-1:0] lim);
        return (p == lim) ? '0 : p + AW'(1);
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // per-cycle decisions (outputs)
    always_comb begin
        push      = 1'b0;
        pop       = 1'b0;
        overwrite = 1'b0;
        ovr_set   = 1'b0;
        if (!flush) begin
            pop = rd_req && (level_q != '0);
            unique case (state_q)
                ST_EMPTY, ST_FILL: push = wr_req;
                ST_FULL: begin
                    if (wr_req && pop) begin
                        push = 1'b1;
                    end else if (wr_req && ovr_ign) begin
                        push      = 1'b1;
                        overwrite = 1'b1;
                    end else if (wr_req) begin
                        ovr_set = 1'b1;
                    end
                end
                ST_STALL: ovr_set = wr_req;
            endcase
        end
        level_d = overwrite ? level_q : (level_q + LW'(push) - LW'(pop));
        drained = pop && !push && (level_q == LW'(1));
    end

    // next state
    always_comb begin
        if (level_d == '0)        settle = ST_EMPTY;
        else if (level_d == depth) settle = ST_FULL;
        else                       settle = ST_FILL;
        state_d = state_q;
        if (flush) begin
            state_d = ST_EMPTY;
        end else begin
            unique case (state_q)
                ST_EMPTY, ST_FILL: state_d = settle;
                ST_FULL:           state_d = ovr_set ? ST_STALL : settle;
                ST_STALL:          state_d = (level_d == '0) ? ST_EMPTY : ST_STALL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            level_q  <= '0;
        end else if (flush) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            level_q  <= '0;
        end else begin
            if (push)              wr_ptr_q <= ptr_next(wr_ptr_q, depth_m1);
            if (pop || overwrite)  rd_ptr_q <= ptr_next(rd_ptr_q, depth_m1);
            level_q <= level_d;
        end
    end

    assign wr_ptr = wr_ptr_q;
    assign rd_ptr = rd_ptr_q;
    assign level  = level_q;
    assign state  = state_q;

endmodule

// File: rtl/rfq_store.sv
`timescale 1ns/1ps
module rfq_store #(
    parameter int DATA_W    = 12,
    parameter int DEPTH_MAX = 64,
    localparam int AW = (DEPTH_MAX > 1) ? $clog2(DEPTH_MAX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    input  logic              rd_req,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_void
);

    logic [DATA_W-1:0] mem [DEPTH_MAX];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
            rd_void <= 1'b1;
        end else if (pop) begin
            rd_data <= mem[raddr];
            rd_void <= 1'b0;
        end else if (rd_req) begin
            rd_void <= 1'b1;
        end
    end

endmodule

// File: rtl/rfq_thresh.sv
`timescale 1ns/1ps
module rfq_thresh #(
    parameter int THR_W   = 8,
    parameter int RST_THR = 4,
    localparam int CNT_W  = THR_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic [THR_W-1:0]        load_val,
    input  logic [THR_W-1:0]        thr_value,
    input  logic                    push,
    input  logic                    pop,
    input  logic                    drained,
    input  logic                    flag_clr,
    output logic signed [CNT_W-1:0] cnt,
    output logic                    flag
);

    localparam logic signed [CNT_W-1:0] CNT_MIN = {1'b1, {(CNT_W-1){1'b0}}};
    localparam logic signed [CNT_W-1:0] CNT_RST = CNT_W'(RST_THR);

    logic signed [CNT_W-1:0] cnt_q;
    logic                    flag_q, hit;

    function automatic logic signed [CNT_W-1:0] widen(input logic [THR_W-1:0] v);
        return $signed({{(CNT_W-THR_W){1'b0}}, v});
    endfunction

    assign hit = push && !pop && (cnt_q == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CNT_RST;
        end else if (flush) begin
            cnt_q <= widen(load_val);
        end else if (drained) begin
            cnt_q <= widen(thr_value);
        end else if (push && !pop) begin
            if (cnt_q != CNT_MIN) cnt_q <= cnt_q - CNT_W'(1);
        end else if (pop && !push) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (hit)      flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    assign cnt  = cnt_q;
    assign flag = flag_q;

endmodule

// File: rtl/rfq_regs.sv
`timescale 1ns/1ps
module rfq_regs
    import rfq_pkg::*;
#(
    parameter int THR_W     = 8,
    parameter int DEPTH_MAX = 64,
    parameter int RST_THR   = 4,
    parameter int REG_W     = 16,
    localparam int AW    = (DEPTH_MAX > 1) ? $clog2(DEPTH_MAX) : 1,
    localparam int LW    = $clog2(DEPTH_MAX + 1),
    localparam int CNT_W = THR_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_we,
    input  logic [2:0]              reg_addr,
    input  logic [REG_W-1:0]        reg_wdata,
    input  logic                    ovr_set,
    input  logic                    thr_flag,
    input  rfq_state_e              state,
    input  logic signed [CNT_W-1:0] cnt,
    input  logic [LW-1:0]           level,
    output logic [THR_W-1:0]        thr_value,
    output logic [THR_W-1:0]        load_val,
    output logic                    irq_en,
    output logic                    ovr_ign,
    output logic [AW-1:0]           depth_m1,
    output logic                    flush,
    output logic                    flag_clr,
    output logic                    ovr_flag,
    output logic [REG_W-1:0]        reg_rdata
);

    localparam logic [AW-1:0] DMAX_M1 = AW'(DEPTH_MAX - 1);

    logic [THR_W-1:0] thr_q;
    logic [AW-1:0]    dep_q, dep_wr;
    logic             ien_q, ign_q, ovr_q;
    logic             wr_thr, wr_dep, wr_ctl, wr_sts;
    logic [4:0]       sts;
    logic             unused_wbits;

    assign wr_thr = reg_we && (reg_addr == RA_THRESH);
    assign wr_dep = reg_we && (reg_addr == RA_DEPTH);
    assign wr_ctl = reg_we && (reg_addr == RA_CTRL);
    assign wr_sts = reg_we && (reg_addr == RA_STATUS);
    assign dep_wr = (reg_wdata[AW-1:0] > DMAX_M1) ? DMAX_M1 : reg_wdata[AW-1:0];
    assign unused_wbits = ^reg_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q <= THR_W'(RST_THR);
            dep_q <= DMAX_M1;
            ien_q <= 1'b0;
            ign_q <= 1'b0;
        end else begin
            if (wr_thr) thr_q <= reg_wdata[THR_W-1:0];
            if (wr_dep) dep_q <= dep_wr;
            if (wr_ctl) begin
                ien_q <= reg_wdata[CB_IEN];
                ign_q <= reg_wdata[CB_IGN];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          ovr_q <= 1'b0;
        else if (ovr_set)                    ovr_q <= 1'b1;
        else if (wr_sts && reg_wdata[SB_OVR]) ovr_q <= 1'b0;
    end

    assign flush     = wr_thr || wr_dep;
    assign load_val  = wr_thr ? reg_wdata[THR_W-1:0] : thr_q;
    assign flag_clr  = wr_sts && reg_wdata[SB_THR];
    assign thr_value = thr_q;
    assign irq_en    = ien_q;
    assign ovr_ign   = ign_q;
    assign depth_m1  = dep_q;
    assign ovr_flag  = ovr_q;

    always_comb begin
        sts           = '0;
        sts[SB_THR]   = thr_flag;
        sts[SB_OVR]   = ovr_q;
        sts[SB_EMPTY] = (state == ST_EMPTY);
        sts[SB_FULL]  = (level == (LW'(dep_q) + LW'(1)));
        sts[SB_STALL] = (state == ST_STALL);
    end

    always_comb begin
        case (reg_addr)
            RA_THRESH: reg_rdata = REG_W'(thr_q);
            RA_CTRL:   reg_rdata = REG_W'({ign_q, ien_q});
            RA_DEPTH:  reg_rdata = REG_W'(dep_q);
            RA_STATUS: reg_rdata = REG_W'(sts);
            RA_COUNT:  reg_rdata = {{(REG_W-CNT_W){cnt[CNT_W-1]}}, cnt};
            RA_LEVEL:  reg_rdata = REG_W'(level);
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/result_fifo_thresh.sv
`timescale 1ns/1ps
module result_fifo_thresh
    import rfq_pkg::*;
#(
    parameter int DATA_W    = 12,
    parameter int DEPTH_MAX = 64,
    parameter int THR_W     = 8,
    parameter int RST_THR   = 4,
    parameter int REG_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_valid,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              cpu_rd,
    output logic [DATA_W-1:0] cpu_data,
    output logic              cpu_void,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              thr_irq
);

    localparam int AW    = (DEPTH_MAX > 1) ? $clog2(DEPTH_MAX) : 1;
    localparam int LW    = $clog2(DEPTH_MAX + 1);
    localparam int CNT_W = THR_W + 2;

    logic [AW-1:0]           wr_ptr, rd_ptr, depth_m1;
    logic                    push, pop, drained, ovr_set, flush;
    logic                    flag_clr, thr_flag, ovr_flag, irq_en, ovr_ign;
    logic [LW-1:0]           level;
    rfq_state_e              state;
    logic [THR_W-1:0]        thr_value, load_val;
    logic signed [CNT_W-1:0] cnt;

    rfq_ctrl #(.DEPTH_MAX(DEPTH_MAX)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .wr_req(conv_valid), .rd_req(cpu_rd), .ovr_ign(ovr_ign),
        .depth_m1(depth_m1), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .push(push), .pop(pop), .drained(drained), .ovr_set(ovr_set),
        .level(level), .state(state)
    );

    rfq_store #(.DATA_W(DATA_W), .DEPTH_MAX(DEPTH_MAX)) u_store (
        .clk(clk), .rst_n(rst_n), .we(push), .waddr(wr_ptr),
        .wdata(conv_data), .pop(pop), .rd_req(cpu_rd), .raddr(rd_ptr),
        .rd_data(cpu_data), .rd_void(cpu_void)
    );

    rfq_thresh #(.THR_W(THR_W), .RST_THR(RST_THR)) u_thresh (
        .clk(clk), .rst_n(rst_n), .flush(flush), .load_val(load_val),
        .thr_value(thr_value), .push(push), .pop(pop), .drained(drained),
        .flag_clr(flag_clr), .cnt(cnt), .flag(thr_flag)
    );

    rfq_regs #(.THR_W(THR_W), .DEPTH_MAX(DEPTH_MAX), .RST_THR(RST_THR),
               .REG_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .ovr_set(ovr_set), .thr_flag(thr_flag),
        .state(state), .cnt(cnt), .level(level), .thr_value(thr_value),
        .load_val(load_val), .irq_en(irq_en), .ovr_ign(ovr_ign),
        .depth_m1(depth_m1), .flush(flush), .flag_clr(flag_clr),
        .ovr_flag(ovr_flag), .reg_rdata(reg_rdata)
    );

    assign thr_irq = thr_flag && irq_en;

endmodule

// File: rtl/rfq_chk.sv
`timescale 1ns/1ps
module rfq_chk
    import rfq_pkg::*;
#(
    parameter int DEPTH_MAX = 64,
    parameter int THR_W     = 8,
    localparam int AW    = (DEPTH_MAX > 1) ? $clog2(DEPTH_MAX) : 1,
    localparam int LW    = $clog2(DEPTH_MAX + 1),
    localparam int CNT_W = THR_W + 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    push,
    input logic                    pop,
    input logic                    drained,
    input logic                    flush,
    input logic                    flag_clr,
    input logic                    cpu_rd,
    input logic signed [CNT_W-1:0] cnt,
    input logic                    thr_flag,
    input logic                    ovr_flag,
    input logic [LW-1:0]           level,
    input logic [AW-1:0]           depth_m1,
    input logic [THR_W-1:0]        thr_value,
    input rfq_state_e              state
);

    // R4
    both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> $stable(cnt));

    // R5
    flag_from_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(thr_flag) |-> ($past(cnt) == CNT_W'(1)));

    // R6
    clear_keeps_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !push && !pop && !flush) |=> $stable(cnt));

    // R7
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drained |=> (cnt == $signed({{(CNT_W-THR_W){1'b0}}, thr_value})));

    // R9
    stall_no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STALL && !flush) |=> (level <= $past(level)));

    // R9
    ovr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag) |-> ($past(state) == ST_FULL || $past(state) == ST_STALL));

    // R10
    void_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && level == '0 && !push && !flush) |=> $stable(cnt));

    // R13
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level <= (LW'(depth_m1) + LW'(1))));

endmodule

bind result_fifo_thresh rfq_chk #(.DEPTH_MAX(DEPTH_MAX), .THR_W(THR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .drained(drained),
    .flush(flush), .flag_clr(flag_clr), .cpu_rd(cpu_rd), .cnt(cnt),
    .thr_flag(thr_flag), .ovr_flag(ovr_flag), .level(level),
    .depth_m1(depth_m1), .thr_value(thr_value), .state(state)
);

// File: tb/result_fifo_thresh_tb.sv
`timescale 1ns/1ps
module result_fifo_thresh_tb;
    import rfq_pkg::*;

    localparam int DW = 12;
    localparam int DM = 8;
    localparam int TW = 8;
    localparam int RT = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          conv_valid = 1'b0;
    logic [DW-1:0] conv_data = '0;
    logic          cpu_rd = 1'b0;
    logic [DW-1:0] cpu_data;
    logic          cpu_void;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic          thr_irq;

    always #2.5 clk = ~clk;

    result_fifo_thresh #(.DATA_W(DW), .DEPTH_MAX(DM), .THR_W(TW),
                         .RST_THR(RT), .REG_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_data(conv_data),
        .cpu_rd(cpu_rd), .cpu_data(cpu_data), .cpu_void(cpu_void),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .thr_irq(thr_irq)
    );

    int n_chk = 0;
    int n_bad = 0;

    int q[$];
    int m_cnt, m_thr, m_depth, m_last;
    bit m_flag, m_ovr, m_stall, m_en, m_ign, m_void;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic reg_chk(input logic [2:0] a, input int exp, input string tag);
        reg_addr = a;
        #0.2;
        if (a == RA_COUNT) chk(tag, int'($signed(reg_rdata)), exp);
        else               chk(tag, int'(reg_rdata), exp);
    endtask

    function automatic int exp_status();
        int s;
        s = 0;
        if (m_flag) s |= 1;
        if (m_ovr) s |= 2;
        if (q.size() == 0) s |= 4;
        if (q.size() == m_depth) s |= 8;
        if (m_stall) s |= 16;
        return s;
    endfunction

    task automatic reg_w(input logic [2:0] a, input int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = 16'(d);
        @(posedge clk);
        #1 reg_we = 1'b0;
    endtask

    task automatic model_flush();
        q.delete();
        m_cnt = m_thr;
        m_stall = 1'b0;
    endtask

    task automatic set_thr(input int t);
        reg_w(RA_THRESH, t);
        m_thr = t; model_flush();
        reg_chk(RA_COUNT, m_cnt, "R11 counter load");
        reg_chk(RA_LEVEL, 0, "R11 level emptied");
    endtask

    task automatic set_depth(input int d);
        reg_w(RA_DEPTH, d - 1);
        m_depth = d; model_flush();
        reg_chk(RA_DEPTH, d - 1, "R13 depth field");
    endtask

    task automatic set_ctrl(input bit en, input bit ign);
        reg_w(RA_CTRL, (int'(ign) << 1) | int'(en));
        m_en = en; m_ign = ign;
    endtask

    task automatic clr_flags();
        reg_w(RA_STATUS, 3);
        m_flag = 1'b0; m_ovr = 1'b0;
        reg_chk(RA_COUNT, m_cnt, "R6 clear keeps counter");
        reg_chk(RA_STATUS, exp_status(), "R6 flags cleared");
    endtask

    task automatic step(input bit wr, input int d, input bit rd);
        bit    pop, push, full_b;
        int    popped;
        string ctag;
        @(negedge clk);
        conv_valid = wr; conv_data = DW'(d); cpu_rd = rd;
        @(posedge clk);
        #1 conv_valid = 1'b0; cpu_rd = 1'b0;
        full_b = (q.size() == m_depth);
        pop = rd && (q.size() > 0);
        push = 1'b0;
        popped = 0;
        if (pop) popped = q.pop_front();
        if (wr) begin
            if (m_stall) begin
                m_ovr = 1'b1;
            end else if (!full_b || pop) begin
                push = 1'b1; q.push_back(d);
            end else if (m_ign) begin
                push = 1'b1; void'(q.pop_front()); q.push_back(d);
            end else begin
                m_stall = 1'b1; m_ovr = 1'b1;
            end
        end
        ctag = "R10 idle counter";
        if (push && pop) begin
            ctag = "R4 counter hold";
        end else if (push) begin
            if (m_cnt == 1) m_flag = 1'b1;
            m_cnt--;
            ctag = (wr && full_b && m_ign) ? "R8 overwrite count" : "R2 counter down";
        end else if (pop) begin
            m_cnt++;
            ctag = "R3 counter up";
            if (q.size() == 0) begin
                m_cnt = m_thr;
                ctag = "R7 reload on empty";
            end
        end
        if (m_stall && q.size() == 0) m_stall = 1'b0;
        if (pop) begin
            m_last = popped; m_void = 1'b0;
        end else if (rd) begin
            m_void = 1'b1;
        end
        if (rd) begin
            chk(pop ? "R1 read data" : "R10 held data", int'(cpu_data), m_last);
            chk("R10 void status", int'(cpu_void), int'(m_void));
        end
        chk("R5 irq", int'(thr_irq), int'(m_flag && m_en));
        reg_chk(RA_COUNT, m_cnt, ctag);
        reg_chk(RA_LEVEL, q.size(), "R13 level");
        reg_chk(RA_STATUS, exp_status(), m_ign ? "R8 status" : "R9 status");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        m_thr = RT; m_depth = DM; m_cnt = RT; m_last = 0; m_void = 1'b1;
        m_flag = 0; m_ovr = 0; m_stall = 0; m_en = 0; m_ign = 0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R14 reset state
        reg_chk(RA_COUNT, RT, "R14 counter");
        reg_chk(RA_LEVEL, 0, "R14 level");
        reg_chk(RA_STATUS, 4, "R14 status");
        reg_chk(RA_CTRL, 0, "R14 ctrl");
        reg_chk(RA_DEPTH, DM - 1, "R14 depth");
        chk("R14 irq", int'(thr_irq), 0);
        chk("R14 void", int'(cpu_void), 1);
        chk("R14 data", int'(cpu_data), 0);

        // R12: counter goes negative; R5 flag with irq disabled then enabled
        set_thr(2);
        for (int i = 0; i < 5; i++) step(1'b1, 100 + i, 1'b0);
        reg_chk(RA_COUNT, -3, "R12 negative counter");
        chk("R5 flag masked", int'(thr_irq), 0);
        set_ctrl(1'b1, 1'b0);
        chk("R5 irq enabled", int'(thr_irq), 1);
        clr_flags();
        chk("R6 irq after clear", int'(thr_irq), 0);
        // R11: reprogramming threshold empties buffer
        set_thr(6);
        // R10: read from empty
        step(1'b0, 0, 1'b1);
        // R8: overwrite with depth 3
        set_ctrl(1'b1, 1'b1);
        set_depth(3);
        for (int i = 1; i <= 5; i++) step(1'b1, i, 1'b0);
        for (int i = 0; i < 4; i++) step(1'b0, 0, 1'b1);
        // R9: stall with depth 3
        set_ctrl(1'b0, 1'b0);
        set_depth(3);
        for (int i = 1; i <= 5; i++) step(1'b1, 20 + i, 1'b0);
        step(1'b0, 0, 1'b1);
        step(1'b1, 99, 1'b0);
        step(1'b1, 98, 1'b1);
        step(1'b0, 0, 1'b1);
        step(1'b1, 7, 1'b0);
        step(1'b0, 0, 1'b1);
        clr_flags();

        // sweep: every depth, both modes, three thresholds
        for (int d = 1; d <= DM; d++) begin
            for (int ig = 0; ig < 2; ig++) begin
                for (int ts = 0; ts < 3; ts++) begin
                    set_ctrl(ts[0], ig[0]);
                    set_depth(d);
                    set_thr((ts == 0) ? 0 : (ts == 1) ? 1 : d + 1);
                    for (int i = 0; i < 40; i++) begin
                        step(((i * 5 + d + ts) % 7) < 4, (d * 256 + i * 3 + ig) % 4096,
                             ((i * 3 + ig + d) % 5) < 2);
                        if (i % 11 == 10) clr_flags();
                    end
                end
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule